// File: doc/BRIEF.md
# Block Address Translation Array

This block translates a 32-bit effective address into a real page address by comparing it against a small set of block-translation entries. Each entry is a pair of 32-bit words: an upper word and a lower word. There are two banks of entries. Instruction fetches look up one bank and data loads and stores look up the other. A request carries the address, an access type and a user/supervisor flag. One cycle later the block returns a hit flag, the 4 KiB-aligned real page address, and the read, write and execute rights that the matching entry grants. The requester decides whether the access is allowed. The block raises no faults and walks no page tables.

Each entry covers an aligned block of memory. The size of the block comes from a length field, which clears low-order bits out of the compare mask. A configuration input limits how many entries take part in the search. A second configuration input selects a legacy entry format. In that format the valid bit and the length field sit in the lower word, and the rights come from a key/protection table. Software loads the entries through a simple indexed write port.

Top module: `bat_xlate_top`

## Requirements
- R1: After reset every entry word in both banks is zero and the response outputs are zero. Any lookup made before the first write misses.
- R2: Access type code 0 (fetch) searches only the instruction bank (`wr_bank`=1). Codes 1 (load), 2 (store) and 3 search only the data bank (`wr_bank`=0).
- R3: In the normal format, an entry is valid for a supervisor request (`req_user`=0) when upper bit 1 is set. It is valid for a user request (`req_user`=1) when upper bit 0 is set.
- R4: The effective-page field is upper[31:17] and the normal length field is upper[12:2]. The 15-bit mask over address bits 31:17 is all ones, with the length field, placed at address bits 27:17, cleared out of it. An entry matches when (ea[31:17] AND mask) equals upper[31:17]. An entry whose page field has a bit set where the mask is zero therefore never matches.
- R5: On a hit, the real address is (lower[31:17] AND mask) OR (ea[31:17] AND NOT mask), followed by ea[16:12] and twelve zero bits.
- R6: In the normal format, lower[1:0] sets the rights: 0 grants nothing, 1 and 3 grant read and execute, and 2 grants read, write and execute.
- R7: When `cfg_legacy`=1, lower bit 6 is the valid bit for both privilege levels. The 6-bit length field lower[5:0] is cleared from the mask at address bits 22:17.
- R8: In the legacy format, the key is upper bit 2 for user requests and upper bit 3 for supervisor requests, and pp is upper[1:0]. With key 0, pp 0 to 2 grant read and write and pp 3 grants read. With key 1, pp 0 grants nothing, pp 1 and 3 grant read, and pp 2 grants read and write. Execute is always granted.
- R9: Only entries with index below `cfg_active` take part in the search. `cfg_active`=0 makes every lookup miss.
- R10: When several entries match, the response uses the lowest-index match.
- R11: `rsp_valid` follows `req_valid` one cycle later. When the response does not hit, `rsp_pa` and all three rights are zero.
- R12: A write with `wr_upper`=1 replaces the upper word of entry `wr_idx` in bank `wr_bank`, and a write with `wr_upper`=0 replaces the lower word. The new value takes effect for requests presented on later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Entry word write strobe |
| wr_bank | input | 1 | 1 = instruction bank, 0 = data bank |
| wr_idx | input | IDXW | Entry index to write |
| wr_upper | input | 1 | 1 = upper word, 0 = lower word |
| wr_data | input | 32 | Word value to write |
| cfg_legacy | input | 1 | Selects the legacy entry format |
| cfg_active | input | CNTW | Number of entries searched |
| req_valid | input | 1 | Lookup request strobe |
| req_ea | input | 32 | Effective address |
| req_type | input | 2 | 0 fetch, 1 load, 2 store |
| req_user | input | 1 | 1 = user, 0 = supervisor |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_hit | output | 1 | An entry matched |
| rsp_pa | output | 32 | Real page address (low 12 bits zero) |
| rsp_rd | output | 1 | Read right |
| rsp_wr | output | 1 | Write right |
| rsp_ex | output | 1 | Execute right |

## Verification
The bench builds the block with six entries per bank. Six is not a power of two, so the index range and the active-count compare both have spare codes. The bench sweeps `cfg_active` from 0 to 6, which reaches the empty search, the full search, and the cut-off between overlapping entries. With six entries, a wide block and a narrow block can cover the same address in both orders, which exercises lowest-index priority. One entry is given a page bit under its own length field, so it can never match.

// File: rtl/bat_xlate_pkg.sv
package bat_xlate_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_OTHER = 2'd3
    } acc_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
    } rights_t;

    typedef struct packed {
        logic        valid;
        logic        hit;
        logic [31:0] pa;
        rights_t     rights;
    } resp_t;

    // Key/protection table used by the legacy entry format
    function automatic rights_t key_rights(input logic key, input logic [1:0] pp);
        rights_t r;
        r.ex = 1'b1;
        if (key) begin
            r.rd = (pp != 2'd0);
            r.wr = (pp == 2'd2);
        end else begin
            r.rd = 1'b1;
            r.wr = (pp != 2'd3);
        end
        return r;
    endfunction

endpackage

// File: rtl/bat_regfile.sv
module bat_regfile #(
    parameter int ENTRIES = 4,
    parameter int IDXW    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic                          wr_bank,
    input  logic [IDXW-1:0]               wr_idx,
    input  logic                          wr_upper,
    input  logic [31:0]                   wr_data,
    input  logic                          sel_instr,
    output logic [ENTRIES-1:0][31:0]      upper_o,
    output logic [ENTRIES-1:0][31:0]      lower_o
);

    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(ENTRIES - 1);

    typedef struct packed {
        logic [1:0][ENTRIES-1:0][31:0] up;
        logic [1:0][ENTRIES-1:0][31:0] lo;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && (wr_idx <= LAST_IDX)) begin
            if (wr_upper) begin
                st_d.up[wr_bank][wr_idx] = wr_data;
            end else begin
                st_d.lo[wr_bank][wr_idx] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign upper_o = st_q.up[sel_instr];
    assign lower_o = st_q.lo[sel_instr];

    // R12: an accepted write lands in the addressed word
    a_r12_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_upper && (wr_idx <= LAST_IDX)) |=>
            (st_q.up[$past(wr_bank)][$past(wr_idx)] == $past(wr_data)));

    a_r12_write_lands_low: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_upper && (wr_idx <= LAST_IDX)) |=>
            (st_q.lo[$past(wr_bank)][$past(wr_idx)] == $past(wr_data)));

endmodule

// File: rtl/bat_entry_eval.sv
module bat_entry_eval
    import bat_xlate_pkg::*;
(
    input  logic [31:0] upper,
    input  logic [31:0] lower,
    input  logic [31:12] ea,
    input  logic        user,
    input  logic        legacy,
    input  logic        enabled,
    output logic        hit,
    output logic [31:0] pa,
    output rights_t     rights
);

    logic [14:0] mask;
    logic        valid;
    logic [14:0] page;
    logic        unused_bits;

    assign page        = upper[31:17];
    assign unused_bits = ^{upper[16:13], lower[16:7]};

    always_comb begin
        if (legacy) begin
            valid  = lower[6];
            mask   = {9'h1FF, ~lower[5:0]};
            rights = key_rights(user ? upper[2] : upper[3], upper[1:0]);
        end else begin
            valid     = user ? upper[0] : upper[1];
            mask      = {4'hF, ~upper[12:2]};
            rights.rd = (lower[1:0] != 2'd0);
            rights.wr = (lower[1:0] == 2'd2);
            rights.ex = (lower[1:0] != 2'd0);
        end
        hit = enabled && valid && ((ea[31:17] & mask) == page);
        pa  = {(lower[31:17] & mask) | (ea[31:17] & ~mask), ea[16:12], 12'h000};
    end

endmodule

// File: rtl/bat_pick.sv
module bat_pick
    import bat_xlate_pkg::*;
#(
    parameter int ENTRIES = 4
) (
    input  logic [ENTRIES-1:0]        hit_v,
    input  logic [ENTRIES-1:0][31:0]  pa_v,
    input  rights_t [ENTRIES-1:0]     rt_v,
    output logic                      any_hit,
    output logic [31:0]               pa,
    output rights_t                   rights
);

    logic [ENTRIES-1:0] grant;

    always_comb begin
        any_hit = 1'b0;
        grant   = '0;
        pa      = '0;
        rights  = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_v[i] && !any_hit) begin
                any_hit  = 1'b1;
                grant[i] = 1'b1;
                pa       = pa_v[i];
                rights   = rt_v[i];
            end
        end
    end

    // R10: at most one entry is granted, and a grant exists whenever any matched
    always_comb begin
        a_r10_single_grant: assert ($onehot0(grant));
        a_r10_grant_iff_hit: assert ((|grant) == (|hit_v));
    end

endmodule

// File: rtl/bat_xlate_top.sv
module bat_xlate_top
    import bat_xlate_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int IDXW    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    parameter int CNTW    = $clog2(ENTRIES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_bank,
    input  logic [IDXW-1:0]  wr_idx,
    input  logic             wr_upper,
    input  logic [31:0]      wr_data,
    input  logic             cfg_legacy,
    input  logic [CNTW-1:0]  cfg_active,
    input  logic             req_valid,
    input  logic [31:0]      req_ea,
    input  logic [1:0]       req_type,
    input  logic             req_user,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [31:0]      rsp_pa,
    output logic             rsp_rd,
    output logic             rsp_wr,
    output logic             rsp_ex
);

    logic                     sel_instr;
    logic [ENTRIES-1:0][31:0] upper_w;
    logic [ENTRIES-1:0][31:0] lower_w;
    logic [ENTRIES-1:0]       hit_v;
    logic [ENTRIES-1:0][31:0] pa_v;
    rights_t [ENTRIES-1:0]    rt_v;
    logic                     any_hit;
    logic [31:0]              win_pa;
    rights_t                  win_rt;
    logic                     unused_offset;
    resp_t                    rsp_d, rsp_q;

    assign sel_instr     = (acc_e'(req_type) == ACC_FETCH);
    assign unused_offset = ^req_ea[11:0];

    bat_regfile #(.ENTRIES(ENTRIES), .IDXW(IDXW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_bank   (wr_bank),
        .wr_idx    (wr_idx),
        .wr_upper  (wr_upper),
        .wr_data   (wr_data),
        .sel_instr (sel_instr),
        .upper_o   (upper_w),
        .lower_o   (lower_w)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        bat_entry_eval u_eval (
            .upper   (upper_w[g]),
            .lower   (lower_w[g]),
            .ea      (req_ea[31:12]),
            .user    (req_user),
            .legacy  (cfg_legacy),
            .enabled (cfg_active > CNTW'(g)),
            .hit     (hit_v[g]),
            .pa      (pa_v[g]),
            .rights  (rt_v[g])
        );
    end

    bat_pick #(.ENTRIES(ENTRIES)) u_pick (
        .hit_v   (hit_v),
        .pa_v    (pa_v),
        .rt_v    (rt_v),
        .any_hit (any_hit),
        .pa      (win_pa),
        .rights  (win_rt)
    );

    always_comb begin
        rsp_d = '0;
        if (req_valid) begin
            rsp_d.valid = 1'b1;
            if (any_hit) begin
                rsp_d.hit    = 1'b1;
                rsp_d.pa     = win_pa;
                rsp_d.rights = win_rt;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_pa    = rsp_q.pa;
    assign rsp_rd    = rsp_q.rights.rd;
    assign rsp_wr    = rsp_q.rights.wr;
    assign rsp_ex    = rsp_q.rights.ex;

    // R11: response strobe trails the request by one cycle
    a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r11_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R11: a miss carries no address and no rights
    a_r11_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> (rsp_pa == 32'h0 && !rsp_rd && !rsp_wr && !rsp_ex));
    // R5: real address is page aligned
    a_r5_page_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_pa[11:0] == 12'h000);
    // R6, R8: write right never comes without read right
    a_r6_write_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_wr |-> rsp_rd);
    // R8: legacy hits always allow execute
    a_r8_legacy_exec: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cfg_legacy) |=> (!rsp_hit || rsp_ex));
    // R9: an empty search never hits
    a_r9_empty_misses: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_active == '0) |=> !rsp_hit);

endmodule

// File: tb/tb_bat_xlate_top.sv
module tb_bat_xlate_top;

    localparam int N    = 6;
    localparam int IDXW = $clog2(N);
    localparam int CNTW = $clog2(N + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic            wr_bank = 1'b0;
    logic [IDXW-1:0] wr_idx = '0;
    logic            wr_upper = 1'b0;
    logic [31:0]     wr_data = '0;
    logic            cfg_legacy = 1'b0;
    logic [CNTW-1:0] cfg_active = CNTW'(N);
    logic            req_valid = 1'b0;
    logic [31:0]     req_ea = '0;
    logic [1:0]      req_type = '0;
    logic            req_user = 1'b0;
    logic            rsp_valid, rsp_hit, rsp_rd, rsp_wr, rsp_ex;
    logic [31:0]     rsp_pa;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    logic [31:0] sh_up [2][N];
    logic [31:0] sh_lo [2][N];

    always #4 clk = ~clk;

    bat_xlate_top #(.ENTRIES(N)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(wr_bank),
        .wr_idx(wr_idx), .wr_upper(wr_upper), .wr_data(wr_data),
        .cfg_legacy(cfg_legacy), .cfg_active(cfg_active),
        .req_valid(req_valid), .req_ea(req_ea), .req_type(req_type),
        .req_user(req_user), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_pa(rsp_pa), .rsp_rd(rsp_rd), .rsp_wr(rsp_wr), .rsp_ex(rsp_ex)
    );

    // Expected {hit, pa, rd, wr, ex} from the requirement text
    function automatic logic [35:0] model(logic [31:0] ea, logic [1:0] typ, logic usr);
        int b = (typ == 2'd0) ? 1 : 0;
        for (int i = 0; i < N; i++) begin
            logic [31:0] u = sh_up[b][i];
            logic [31:0] l = sh_lo[b][i];
            logic [14:0] m;
            logic v;
            logic [2:0] rt;
            if (i >= int'(cfg_active)) continue;
            if (cfg_legacy) begin
                logic k = usr ? u[2] : u[3];
                v = l[6];
                m = ~{9'h0, l[5:0]};
                if (!k) rt = (u[1:0] == 2'd3) ? 3'b101 : 3'b111;
                else case (u[1:0])
                    2'd0: rt = 3'b001;
                    2'd2: rt = 3'b111;
                    default: rt = 3'b101;
                endcase
            end else begin
                v = usr ? u[0] : u[1];
                m = ~{4'h0, u[12:2]};
                case (l[1:0])
                    2'd0: rt = 3'b000;
                    2'd2: rt = 3'b111;
                    default: rt = 3'b101;
                endcase
            end
            if (v && ((ea[31:17] & m) == u[31:17]))
                return {1'b1, (l[31:17] & m) | (ea[31:17] & ~m), ea[16:12], 12'h0, rt};
        end
        return 36'h0;
    endfunction

    task automatic wr(input logic bank, input int idx, input logic up, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_bank = bank; wr_idx = IDXW'(idx); wr_upper = up; wr_data = d;
        if (up) sh_up[bank][idx] = d; else sh_lo[bank][idx] = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cmp(input string tag, input logic [36:0] act, input logic [36:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic req(input string tag, input logic [31:0] ea, input logic [1:0] typ, input logic usr);
        logic [35:0] e;
        @(negedge clk);
        req_valid = 1'b1; req_ea = ea; req_type = typ; req_user = usr;
        e = model(ea, typ, usr);
        @(negedge clk);
        req_valid = 1'b0;
        cmp(tag, {rsp_valid, rsp_hit, rsp_pa, rsp_rd, rsp_wr, rsp_ex}, {1'b1, e});
    endtask

    task automatic fixed(input string tag, input logic [31:0] ea, input logic [1:0] typ,
                         input logic usr, input logic [35:0] e);
        @(negedge clk);
        req_valid = 1'b1; req_ea = ea; req_type = typ; req_user = usr;
        @(negedge clk);
        req_valid = 1'b0;
        cmp(tag, {rsp_valid, rsp_hit, rsp_pa, rsp_rd, rsp_wr, rsp_ex}, {1'b1, e});
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < N; i++) begin sh_up[b][i] = '0; sh_lo[b][i] = '0; end
        repeat (3) @(negedge clk);
        // R1: reset state of the response
        cmp("R1 reset outputs", {rsp_valid, rsp_hit, rsp_pa, rsp_rd, rsp_wr, rsp_ex}, '0);
        rst_n = 1'b1;
        fixed("R1 empty lookup misses", 32'h2000_1234, 2'd1, 1'b0, 36'h0);

        // R3/R12: supervisor-only data entry
        wr(1'b0, 0, 1'b1, 32'h2000_0002);
        wr(1'b0, 0, 1'b0, 32'h8000_0002);
        fixed("R3 supervisor valid hit", 32'h2000_1234, 2'd1, 1'b0, {1'b1, 32'h8000_1000, 3'b111});
        fixed("R3 user not valid", 32'h2000_1234, 2'd2, 1'b1, 36'h0);
        // R2: fetch sees the instruction bank only
        fixed("R2 fetch misses data bank", 32'h2000_1234, 2'd0, 1'b0, 36'h0);
        wr(1'b1, 0, 1'b1, 32'h2000_0003);
        wr(1'b1, 0, 1'b0, 32'h4000_0001);
        fixed("R2 fetch hits instr bank", 32'h2000_1234, 2'd0, 1'b1, {1'b1, 32'h4000_1000, 3'b101});
        fixed("R6 data still data bank", 32'h2000_1234, 2'd1, 1'b0, {1'b1, 32'h8000_1000, 3'b111});
        // R4/R5: widest length
        wr(1'b0, 1, 1'b1, 32'h3000_0000 | (32'h7FF << 2) | 32'h3);
        wr(1'b0, 1, 1'b0, 32'h5000_0003);
        fixed("R5 wide block address", 32'h3ABC_D567, 2'd1, 1'b1, {1'b1, 32'h5ABC_D000, 3'b101});
        // R4: page bit under the length field never matches
        wr(1'b0, 2, 1'b1, 32'h4002_0000 | (32'h1 << 2) | 32'h3);
        wr(1'b0, 2, 1'b0, 32'h9000_0002);
        fixed("R4 masked page bit set", 32'h4002_0000, 2'd1, 1'b0, 36'h0);
        fixed("R4 masked page bit clear", 32'h4000_0000, 2'd1, 1'b0, 36'h0);
        // R6: pp 0 hit with no rights
        wr(1'b0, 5, 1'b1, 32'h7000_0003);
        wr(1'b0, 5, 1'b0, 32'h7000_0000);
        fixed("R6 pp0 no rights", 32'h7000_0000, 2'd2, 1'b0, {1'b1, 32'h7000_0000, 3'b000});
        // R10: overlap between entries 3 and 4
        wr(1'b0, 4, 1'b1, 32'h6000_0000 | (32'h7FF << 2) | 32'h3);
        wr(1'b0, 4, 1'b0, 32'hA000_0002);
        wr(1'b0, 3, 1'b1, 32'h6000_0003);
        wr(1'b0, 3, 1'b0, 32'hB000_0001);
        fixed("R10 lowest index wins", 32'h6000_0ABC, 2'd1, 1'b0, {1'b1, 32'hB000_0000, 3'b101});
        fixed("R10 only wide entry", 32'h6123_4000, 2'd1, 1'b0, {1'b1, 32'hA123_4000, 3'b111});
        // R9: active count
        @(negedge clk); cfg_active = CNTW'(4);
        fixed("R9 entry 4 excluded", 32'h6123_4000, 2'd1, 1'b0, 36'h0);
        @(negedge clk); cfg_active = '0;
        fixed("R9 zero active misses", 32'h2000_1234, 2'd1, 1'b0, 36'h0);
        @(negedge clk); cfg_active = CNTW'(N);
        // R7/R8: legacy format
        wr(1'b0, 1, 1'b0, 32'h7000_007F);
        wr(1'b0, 1, 1'b1, 32'h0800_0008);
        @(negedge clk); cfg_legacy = 1'b1;
        fixed("R8 supervisor key1 pp0", 32'h0812_3456, 2'd1, 1'b0, {1'b1, 32'h7012_3000, 3'b001});
        fixed("R8 user key0 pp0", 32'h0812_3456, 2'd2, 1'b1, {1'b1, 32'h7012_3000, 3'b111});
        fixed("R7 outside legacy block", 32'h0880_0000, 2'd1, 1'b0, 36'h0);
        // R11: idle cycle
        @(negedge clk);
        @(negedge clk);
        cmp("R11 idle response", {rsp_valid, rsp_hit, rsp_pa, rsp_rd, rsp_wr, rsp_ex}, '0);

        // Random phase
        for (int it = 0; it < 600; it++) begin
            int sel = $urandom_range(0, 9);
            if (sel < 3) begin
                logic [31:0] d = $urandom();
                if ($urandom_range(0, 1) == 1) d[16:2] = d[16:2] & 15'h0F0F;
                wr(1'($urandom_range(0, 1)), $urandom_range(0, N - 1), 1'($urandom_range(0, 1)), d);
            end else if (sel == 3) begin
                @(negedge clk);
                cfg_active = CNTW'($urandom_range(0, N));
                cfg_legacy = 1'($urandom_range(0, 1));
            end else begin
                logic [1:0]  t = 2'($urandom_range(0, 3));
                int          b = (t == 2'd0) ? 1 : 0;
                logic [31:0] ea = $urandom();
                if ($urandom_range(0, 3) != 0)
                    ea[31:17] = sh_up[b][$urandom_range(0, N - 1)][31:17] ^ 15'($urandom_range(0, 3) << 1);
                req("R5 R6 R8 random lookup", ea, t, 1'($urandom_range(0, 1)));
            end
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule